// File: doc/BRIEF.md
# Mesh Vertex Microcode Sequencer

This block is the control unit of a small programmable vertex engine. Software first sets three things: a base address in memory, the last column index and the last row index of a two-dimensional mesh. It then sets the start bit. The sequencer visits every mesh point, row by row. For each point it writes the column and row numbers into the first two general registers and runs the microcode program from address 0, issuing one instruction per cycle. When it reaches the vector-output opcode, it sends two 32-bit words to memory at an address derived from the point's coordinates, then moves to the next point. When the mesh is finished, it records the number of points visited and raises a one-cycle interrupt.

Instructions other than the vector-output opcode are handed to the arithmetic units through an issue port. Those units are not part of this block. Memory writes go out on a simple request/acknowledge port, and the sequencer waits for each acknowledge. A per-point instruction budget stops a program that never emits its output. Software loads microcode one page at a time through a paged window.

Top module: `mesh_seq_top`

## Requirements
- R1: A register write to word 0 with bit 0 set starts a run when the block is idle. Reading word 0 returns the busy flag in bit 0, which is 1 during a run and 0 otherwise. A write to word 0 with bit 0 clear starts nothing.
- R2: A start write that arrives during a run is ignored: the run is not restarted, and only one interrupt and one set of memory writes result.
- R3: Points are visited with the row index y as the outer loop, from 0 to the last row (word 3) inclusive. The column index x is the inner loop, from 0 to the last column (word 2) inclusive.
- R4: Before each point runs, general register 0 holds x and general register 1 holds y. General registers are read and written at word addresses 0x100 to 0x17F.
- R5: An instruction word has this layout: bits 10:7 are the opcode, bits 24:18 source A, bits 17:11 source B and bits 6:0 the destination. Every point runs from PC 0 with one instruction per cycle. Each instruction whose opcode is not 7 appears for one cycle on the issue port, in program order.
- R6: Opcode 7 writes two words. The first goes to address base + 8 × (128 × y + x), where base is word 1. The second goes to that address + 4.
- R7: The first word is general register A and the second is general register B, each sent big-endian: the value's bits 7:0 travel on data bits 31:24, and the other bytes are reversed the same way.
- R8: A memory write request keeps its address and data unchanged until the acknowledge arrives. No instruction is issued while the request is pending.
- R9: After a run, the last-DMA register (word 8) holds the address of the last word written.
- R10: If a point executes 2048 instructions without an opcode 7, the sequencer abandons that point without writing memory and continues with the next point.
- R11: When a run ends, the vertex count register (word 5) holds (last column + 1) × (last row + 1). The PC (word 9) reads 0.
- R12: Each run ends with exactly one interrupt pulse, one cycle long, and the block is idle during that cycle.
- R13: The microcode window at word addresses 0x200 to 0x3FF reaches code address page × 512 + (word address − 0x200), where page is word 4. The PC spans the whole code store, so execution runs on past a page boundary.
- R14: After reset the block is idle, word 0, the vertex count, the last-DMA register and the PC read 0, and no request, issue or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 10 | Register word address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from csr_addr |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 32 | Memory write data, byte-reversed |
| mem_ack | input | 1 | Memory write accepted this cycle |
| exec_valid | output | 1 | Issue strobe for the arithmetic units |
| exec_word | output | 32 | Issued instruction word |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that software leaves the mesh limits, the base address and the code page alone while a run is in progress. They also assume the memory side raises the acknowledge only while a request is pending. The stimulus programs everything before each start write, touches only the control word during a run, and drives the acknowledge from the current request state. That acknowledge is held back at random, so the hold-until-accepted rule gets exercised.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int WORD_W      = 32;
    localparam int GREG_IDX_W  = 7;
    localparam int MESH_STRIDE = 128;
    localparam int PAGE_OFS_W  = 9;

    typedef enum logic [3:0] {
        OPC_IDLE   = 4'd0,
        OPC_ADD    = 4'd1,
        OPC_SUB    = 4'd2,
        OPC_MUL    = 4'd3,
        OPC_MAG    = 4'd4,
        OPC_TOINT  = 4'd5,
        OPC_TOFLT  = 4'd6,
        OPC_EMIT   = 4'd7,
        OPC_SINE   = 4'd8,
        OPC_COSINE = 4'd9,
        OPC_GT     = 4'd10,
        OPC_EQ     = 4'd11,
        OPC_MOVE   = 4'd12,
        OPC_SELECT = 4'd13,
        OPC_SIGN   = 4'd14,
        OPC_RSQRT  = 4'd15
    } opcode_e;

    typedef struct packed {
        logic [6:0]            spare;
        logic [GREG_IDX_W-1:0] src_a;
        logic [GREG_IDX_W-1:0] src_b;
        opcode_e               op;
        logic [GREG_IDX_W-1:0] dst;
    } insn_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_EXEC,
        ST_WR_A,
        ST_WR_B,
        ST_NEXT,
        ST_DONE
    } seq_state_e;

    localparam logic [9:0] CSR_CTL     = 10'd0;
    localparam logic [9:0] CSR_BASE    = 10'd1;
    localparam logic [9:0] CSR_HLAST   = 10'd2;
    localparam logic [9:0] CSR_VLAST   = 10'd3;
    localparam logic [9:0] CSR_PAGE    = 10'd4;
    localparam logic [9:0] CSR_VCOUNT  = 10'd5;
    localparam logic [9:0] CSR_SPARE0  = 10'd6;
    localparam logic [9:0] CSR_SPARE1  = 10'd7;
    localparam logic [9:0] CSR_LASTDMA = 10'd8;
    localparam logic [9:0] CSR_PC      = 10'd9;
    localparam logic [9:0] CSR_SPARE2  = 10'd10;
    localparam logic [9:0] CSR_SPARE3  = 10'd11;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [WORD_W-1:0] vertex_addr(input logic [WORD_W-1:0] base,
                                                      input logic [WORD_W-1:0] x,
                                                      input logic [WORD_W-1:0] y);
        logic [WORD_W-1:0] idx;
        idx = y * WORD_W'(MESH_STRIDE) + x;
        return base + (idx << 3);
    endfunction

endpackage

// File: rtl/mseq_store.sv
module mseq_store
    import mseq_pkg::*;
#(
    parameter int GREG_N     = 128,
    parameter int CODE_DEPTH = 2048,
    localparam int CA_W      = $clog2(CODE_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sw_gpr_we,
    input  logic [GREG_IDX_W-1:0] sw_gpr_idx,
    input  logic                  sw_code_we,
    input  logic [CA_W-1:0]       sw_code_addr,
    input  logic [WORD_W-1:0]     sw_wdata,
    output logic [WORD_W-1:0]     sw_gpr_rdata,
    output logic [WORD_W-1:0]     sw_code_rdata,
    input  logic                  seq_load,
    input  logic [WORD_W-1:0]     seq_x,
    input  logic [WORD_W-1:0]     seq_y,
    input  logic [CA_W-1:0]       fetch_addr,
    output logic [WORD_W-1:0]     fetch_word,
    input  logic [GREG_IDX_W-1:0] rd_a_idx,
    input  logic [GREG_IDX_W-1:0] rd_b_idx,
    output logic [WORD_W-1:0]     rd_a,
    output logic [WORD_W-1:0]     rd_b
);

    logic [WORD_W-1:0] gpr [GREG_N];
    logic [WORD_W-1:0] code_mem [CODE_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GREG_N; i++) gpr[i] <= '0;
        end else begin
            if (sw_gpr_we) gpr[sw_gpr_idx] <= sw_wdata;
            if (seq_load) begin
                gpr[0] <= seq_x;
                gpr[1] <= seq_y;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (sw_code_we) code_mem[sw_code_addr] <= sw_wdata;
    end

    assign sw_gpr_rdata  = gpr[sw_gpr_idx];
    assign sw_code_rdata = code_mem[sw_code_addr];
    assign fetch_word    = code_mem[fetch_addr];
    assign rd_a          = gpr[rd_a_idx];
    assign rd_b          = gpr[rd_b_idx];

    // R4: coordinates reach the first two general registers one cycle after a load
    a_r4_xy_loaded: assert property (@(posedge clk) disable iff (rst)
        seq_load |=> (gpr[0] == $past(seq_x)) && (gpr[1] == $past(seq_y)));

endmodule

// File: rtl/mseq_mesh.sv
module mseq_mesh #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [IDX_W-1:0] hlast,
    input  logic [IDX_W-1:0] vlast,
    output logic [IDX_W-1:0] x,
    output logic [IDX_W-1:0] y,
    output logic             last
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            x <= '0;
            y <= '0;
        end else if (step) begin
            if (x == hlast) begin
                x <= '0;
                y <= y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end

    assign last = (x == hlast) && (y == vlast);

    // R3: each step either advances the column or opens the next row at column 0
    a_r3_walk_order: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> ((x == $past(x) + 1'b1) && (y == $past(y)))
                          || ((x == '0) && (y == $past(y) + 1'b1)));

endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
    import mseq_pkg::*;
#(
    parameter int RUN_LIMIT = 2048,
    parameter int CA_W      = 11,
    parameter int IDX_W     = 7,
    localparam int CNT_W    = $clog2(RUN_LIMIT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [WORD_W-1:0]     mesh_base,
    input  logic [IDX_W-1:0]      hlast,
    input  logic [IDX_W-1:0]      vlast,
    input  logic [WORD_W-1:0]     fetch_word,
    input  logic [WORD_W-1:0]     rd_a,
    input  logic [WORD_W-1:0]     rd_b,
    input  logic [IDX_W-1:0]      mesh_x,
    input  logic [IDX_W-1:0]      mesh_y,
    input  logic                  mesh_last,
    input  logic                  mem_ack,
    output logic [CA_W-1:0]       pc,
    output logic [GREG_IDX_W-1:0] rd_a_idx,
    output logic [GREG_IDX_W-1:0] rd_b_idx,
    output logic                  seq_load,
    output logic                  mesh_clear,
    output logic                  mesh_step,
    output logic                  mem_req,
    output logic [WORD_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_data,
    output logic                  exec_valid,
    output logic [WORD_W-1:0]     exec_word,
    output logic                  busy,
    output logic                  irq,
    output logic [WORD_W-1:0]     vert_count,
    output logic [WORD_W-1:0]     last_dma
);

    seq_state_e        state;
    insn_t             insn;
    logic [CNT_W-1:0]  run_cnt;
    logic [WORD_W-1:0] word_b_hold;

    assign insn       = insn_t'(fetch_word);
    assign rd_a_idx   = insn.src_a;
    assign rd_b_idx   = insn.src_b;
    assign busy       = (state != ST_IDLE);
    assign seq_load   = (state == ST_LOAD);
    assign mesh_clear = (state == ST_IDLE) && start;
    assign mesh_step  = (state == ST_NEXT) && !mesh_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            pc          <= '0;
            run_cnt     <= '0;
            mem_req     <= 1'b0;
            mem_addr    <= '0;
            mem_data    <= '0;
            word_b_hold <= '0;
            exec_valid  <= 1'b0;
            exec_word   <= '0;
            irq         <= 1'b0;
            vert_count  <= '0;
            last_dma    <= '0;
        end else begin
            irq        <= 1'b0;
            exec_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) state <= ST_LOAD;
                end
                ST_LOAD: begin
                    pc      <= '0;
                    run_cnt <= '0;
                    state   <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (insn.op == OPC_EMIT) begin
                        mem_req     <= 1'b1;
                        mem_addr    <= vertex_addr(mesh_base, WORD_W'(mesh_x), WORD_W'(mesh_y));
                        mem_data    <= swap_bytes(rd_a);
                        word_b_hold <= swap_bytes(rd_b);
                        state       <= ST_WR_A;
                    end else begin
                        exec_valid <= 1'b1;
                        exec_word  <= fetch_word;
                        pc         <= pc + 1'b1;
                        if (run_cnt == CNT_W'(RUN_LIMIT - 1)) state <= ST_NEXT;
                        else run_cnt <= run_cnt + 1'b1;
                    end
                end
                ST_WR_A: begin
                    if (mem_ack) begin
                        mem_addr <= mem_addr + 32'd4;
                        mem_data <= word_b_hold;
                        state    <= ST_WR_B;
                    end
                end
                ST_WR_B: begin
                    if (mem_ack) begin
                        mem_req  <= 1'b0;
                        last_dma <= mem_addr;
                        state    <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    pc    <= '0;
                    state <= mesh_last ? ST_DONE : ST_LOAD;
                end
                ST_DONE: begin
                    irq        <= 1'b1;
                    vert_count <= (WORD_W'(hlast) + 32'd1) * (WORD_W'(vlast) + 32'd1);
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: a pending write keeps its address and data until accepted
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_data));

    // R8: issue and memory writes never overlap
    a_r8_no_issue_while_writing: assert property (@(posedge clk) disable iff (rst)
        exec_valid |-> !mem_req);

    // R12: the completion pulse lasts one cycle
    a_r12_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R12: the block is idle while the completion pulse is high
    a_r12_irq_idle: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

    // R2: a start during a run leaves the sequencer running
    a_r2_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && state != ST_DONE) |=> busy);

endmodule

// File: rtl/mesh_seq_top.sv
module mesh_seq_top
    import mseq_pkg::*;
#(
    parameter int CODE_PAGES = 4,
    parameter int RUN_LIMIT  = 2048,
    parameter int IDX_W      = 7,
    localparam int PAGE_W    = $clog2(CODE_PAGES),
    localparam int CA_W      = PAGE_W + PAGE_OFS_W,
    localparam int CODE_DEPTH = 1 << CA_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_we,
    input  logic [9:0]  csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_data,
    input  logic        mem_ack,
    output logic        exec_valid,
    output logic [31:0] exec_word,
    output logic        irq
);

    logic [WORD_W-1:0] mesh_base;
    logic [IDX_W-1:0]  hlast, vlast;
    logic [PAGE_W-1:0] code_page;
    logic [WORD_W-1:0] spare_q [4];

    logic              in_gpr, in_code, start, busy;
    logic [1:0]        spare_slot;
    logic [CA_W-1:0]   sw_code_addr, pc;
    logic [WORD_W-1:0] sw_gpr_rdata, sw_code_rdata, fetch_word, rd_a, rd_b;
    logic [GREG_IDX_W-1:0] rd_a_idx, rd_b_idx;
    logic              seq_load, mesh_clear, mesh_step, mesh_last;
    logic [IDX_W-1:0]  mesh_x, mesh_y;
    logic [WORD_W-1:0] vert_count, last_dma;

    assign in_gpr       = (csr_addr[9:7] == 3'b010);
    assign in_code      = csr_addr[9];
    assign sw_code_addr = {code_page, csr_addr[PAGE_OFS_W-1:0]};
    assign spare_slot   = {csr_addr[3], csr_addr[0]};
    assign start        = csr_we && (csr_addr == CSR_CTL) && csr_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mesh_base <= '0;
            hlast     <= '0;
            vlast     <= '0;
            code_page <= '0;
            for (int i = 0; i < 4; i++) spare_q[i] <= '0;
        end else if (csr_we && !in_gpr && !in_code) begin
            case (csr_addr)
                CSR_BASE:  mesh_base <= csr_wdata;
                CSR_HLAST: hlast     <= csr_wdata[IDX_W-1:0];
                CSR_VLAST: vlast     <= csr_wdata[IDX_W-1:0];
                CSR_PAGE:  code_page <= csr_wdata[PAGE_W-1:0];
                CSR_SPARE0, CSR_SPARE1, CSR_SPARE2, CSR_SPARE3:
                    spare_q[spare_slot] <= csr_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (in_code) begin
            csr_rdata = sw_code_rdata;
        end else if (in_gpr) begin
            csr_rdata = sw_gpr_rdata;
        end else begin
            case (csr_addr)
                CSR_CTL:     csr_rdata = {31'b0, busy};
                CSR_BASE:    csr_rdata = mesh_base;
                CSR_HLAST:   csr_rdata = WORD_W'(hlast);
                CSR_VLAST:   csr_rdata = WORD_W'(vlast);
                CSR_PAGE:    csr_rdata = WORD_W'(code_page);
                CSR_VCOUNT:  csr_rdata = vert_count;
                CSR_LASTDMA: csr_rdata = last_dma;
                CSR_PC:      csr_rdata = WORD_W'(pc);
                CSR_SPARE0, CSR_SPARE1, CSR_SPARE2, CSR_SPARE3:
                    csr_rdata = spare_q[spare_slot];
                default:     csr_rdata = '0;
            endcase
        end
    end

    mseq_store #(
        .GREG_N     (128),
        .CODE_DEPTH (CODE_DEPTH)
    ) store_i (
        .clk           (clk),
        .rst           (rst),
        .sw_gpr_we     (csr_we && in_gpr),
        .sw_gpr_idx    (csr_addr[GREG_IDX_W-1:0]),
        .sw_code_we    (csr_we && in_code),
        .sw_code_addr  (sw_code_addr),
        .sw_wdata      (csr_wdata),
        .sw_gpr_rdata  (sw_gpr_rdata),
        .sw_code_rdata (sw_code_rdata),
        .seq_load      (seq_load),
        .seq_x         (WORD_W'(mesh_x)),
        .seq_y         (WORD_W'(mesh_y)),
        .fetch_addr    (pc),
        .fetch_word    (fetch_word),
        .rd_a_idx      (rd_a_idx),
        .rd_b_idx      (rd_b_idx),
        .rd_a          (rd_a),
        .rd_b          (rd_b)
    );

    mseq_mesh #(
        .IDX_W (IDX_W)
    ) mesh_i (
        .clk   (clk),
        .rst   (rst),
        .clear (mesh_clear),
        .step  (mesh_step),
        .hlast (hlast),
        .vlast (vlast),
        .x     (mesh_x),
        .y     (mesh_y),
        .last  (mesh_last)
    );

    mseq_ctrl #(
        .RUN_LIMIT (RUN_LIMIT),
        .CA_W      (CA_W),
        .IDX_W     (IDX_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mesh_base  (mesh_base),
        .hlast      (hlast),
        .vlast      (vlast),
        .fetch_word (fetch_word),
        .rd_a       (rd_a),
        .rd_b       (rd_b),
        .mesh_x     (mesh_x),
        .mesh_y     (mesh_y),
        .mesh_last  (mesh_last),
        .mem_ack    (mem_ack),
        .pc         (pc),
        .rd_a_idx   (rd_a_idx),
        .rd_b_idx   (rd_b_idx),
        .seq_load   (seq_load),
        .mesh_clear (mesh_clear),
        .mesh_step  (mesh_step),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .exec_valid (exec_valid),
        .exec_word  (exec_word),
        .busy       (busy),
        .irq        (irq),
        .vert_count (vert_count),
        .last_dma   (last_dma)
    );

endmodule

// File: tb/mesh_seq_top_tb.sv
module mesh_seq_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [9:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mem_req;
    logic [31:0] mem_addr, mem_data;
    logic        mem_ack = 1'b0;
    logic        exec_valid;
    logic [31:0] exec_word;
    logic        irq;

    mesh_seq_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_ack    (mem_ack),
        .exec_valid (exec_valid),
        .exec_word  (exec_word),
        .irq        (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cycles = 0;
    bit          ack_rand = 1'b0;

    int unsigned wr_n = 0;
    logic [31:0] wr_addr [64];
    logic [31:0] wr_data [64];
    int unsigned exec_n = 0;
    logic [31:0] exec_log [64];
    int unsigned irq_n = 0;
    logic [31:0] gv [128];
    logic [31:0] prog [8];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst) begin
            if (mem_req && mem_ack) begin
                if (wr_n < 64) begin
                    wr_addr[wr_n] <= mem_addr;
                    wr_data[wr_n] <= mem_data;
                end
                wr_n <= wr_n + 1;
            end
            if (exec_valid) begin
                if (exec_n < 64) exec_log[exec_n] <= exec_word;
                exec_n <= exec_n + 1;
            end
            if (irq) irq_n <= irq_n + 1;
        end
    end

    always @(negedge clk) begin
        if (rst) mem_ack <= 1'b0;
        else mem_ack <= mem_req && (ack_rand ? (($urandom % 3) == 0) : 1'b1);
    end

    always @(negedge clk) begin
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input int x, input int y);
        return base + 32'(8 * (128 * y + x));
    endfunction

    function automatic logic [31:0] reg_val(input int idx, input int x, input int y);
        if (idx == 0) return 32'(x);
        if (idx == 1) return 32'(y);
        return gv[idx];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic clear_logs();
        wr_n = 0; exec_n = 0; irq_n = 0;
    endtask

    // start, confirm busy (R1), poke start again mid-run (R2), wait for completion
    task automatic run_mesh();
        logic [31:0] rd;
        clear_logs();
        csr_write(10'd0, 32'd1);
        csr_read(10'd0, rd);
        chk("R1 busy readback", rd, 32'd1);
        csr_write(10'd0, 32'd1);
        for (int i = 0; i < 20000 && irq_n == 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R12 one interrupt", 32'(irq_n), 32'd1);
        csr_read(10'd0, rd);
        chk("R1 idle after run", rd, 32'd0);
        csr_read(10'd9, rd);
        chk("R11 pc reads zero", rd, 32'd0);
    endtask

    task automatic random_case(input int hl, input int vl, input int k);
        logic [31:0] base, rd, exp;
        int a, b, v, n;
        base = $urandom;
        a = $urandom % 128;
        b = $urandom % 128;
        if (a >= 2) begin gv[a] = $urandom; csr_write(10'h100 + 10'(a), gv[a]); end
        if (b >= 2) begin gv[b] = $urandom; csr_write(10'h100 + 10'(b), gv[b]); end
        csr_write(10'd1, base);
        csr_write(10'd2, 32'(hl));
        csr_write(10'd3, 32'(vl));
        csr_write(10'd4, 32'd0);
        for (int i = 0; i < k; i++) begin
            int op;
            op = $urandom % 15;
            if (op >= 7) op++;
            prog[i] = {$urandom} & 32'hFFFF_F87F;
            prog[i][10:7] = 4'(op);
            csr_write(10'h200 + 10'(i), prog[i]);
        end
        csr_write(10'h200 + 10'(k), {7'd0, 7'(a), 7'(b), 4'd7, 7'd0});
        run_mesh();
        v = (hl + 1) * (vl + 1);
        chk("R3 write count", 32'(wr_n), 32'(2 * v));
        n = 0;
        for (int y = 0; y <= vl; y++) begin
            for (int x = 0; x <= hl; x++) begin
                chk("R6 first word address", wr_addr[n], exp_addr(base, x, y));
                chk("R7 first word data R4", wr_data[n], bswap(reg_val(a, x, y)));
                chk("R6 second word address", wr_addr[n+1], exp_addr(base, x, y) + 32'd4);
                chk("R7 second word data", wr_data[n+1], bswap(reg_val(b, x, y)));
                n += 2;
            end
        end
        chk("R5 issue count", 32'(exec_n), 32'(v * k));
        for (int i = 0; i < v * k && i < 64; i++)
            chk("R5 issue order", exec_log[i], prog[i % k]);
        csr_read(10'd5, rd);
        chk("R11 vertex count", rd, 32'(v));
        csr_read(10'd8, rd);
        exp = exp_addr(base, hl, vl) + 32'd4;
        chk("R9 last dma", rd, exp);
        csr_read(10'h100, rd);
        chk("R4 gpr0 last x", rd, 32'(hl));
        csr_read(10'h101, rd);
        chk("R4 gpr1 last y", rd, 32'(vl));
        for (int i = 0; i <= k; i++) csr_write(10'h200 + 10'(i), 32'd0);
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) gv[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R14 reset state
        chk("R14 mem_req", 32'(mem_req), 32'd0);
        chk("R14 irq", 32'(irq), 32'd0);
        chk("R14 exec_valid", 32'(exec_valid), 32'd0);
        csr_read(10'd0, rd);  chk("R14 control", rd, 32'd0);
        csr_read(10'd5, rd);  chk("R14 vertex count", rd, 32'd0);
        csr_read(10'd8, rd);  chk("R14 last dma", rd, 32'd0);
        csr_read(10'd9, rd);  chk("R14 pc", rd, 32'd0);

        // fill every code page with the idle opcode
        for (int p = 0; p < 4; p++) begin
            csr_write(10'd4, 32'(p));
            for (int i = 0; i < 512; i++) csr_write(10'h200 + 10'(i), 32'd0);
        end

        // R1: control write without bit 0 does nothing
        clear_logs();
        csr_write(10'd0, 32'd2);
        repeat (30) @(negedge clk);
        csr_read(10'd0, rd);
        chk("R1 no start on bit0 clear", rd, 32'd0);
        chk("R1 no writes on bit0 clear", 32'(wr_n + irq_n + exec_n), 32'd0);

        // directed single point, then random meshes with random acknowledge delay
        random_case(0, 0, 1);
        ack_rand = 1'b1;
        for (int t = 0; t < 6; t++)
            random_case($urandom % 4, $urandom % 3, 1 + ($urandom % 5));

        // R10: no emit opcode anywhere, two points each hit the budget
        csr_write(10'd2, 32'd1);
        csr_write(10'd3, 32'd0);
        run_mesh();
        chk("R10 no memory writes", 32'(wr_n), 32'd0);
        chk("R10 issue count at budget", 32'(exec_n), 32'd4096);
        csr_read(10'd5, rd);
        chk("R11 vertex count after abandon", rd, 32'd2);

        // R13: emit word placed on page 1 offset 5, run crosses the page boundary
        csr_write(10'd4, 32'd1);
        csr_write(10'h205, {7'd0, 7'd0, 7'd1, 4'd7, 7'd0});
        csr_read(10'h205, rd);
        chk("R13 page 1 readback", rd, {7'd0, 7'd0, 7'd1, 4'd7, 7'd0});
        csr_write(10'd4, 32'd0);
        csr_read(10'h205, rd);
        chk("R13 page 0 separate", rd, 32'd0);
        csr_write(10'd1, 32'h0001_0000);
        csr_write(10'd2, 32'd0);
        csr_write(10'd3, 32'd1);
        run_mesh();
        chk("R13 issue count per point", 32'(exec_n), 32'd1034);
        chk("R13 write count", 32'(wr_n), 32'd4);
        chk("R13 row 1 address", wr_addr[2], 32'h0001_0000 + 32'd1024);
        chk("R13 row 1 y data", wr_data[3], bswap(32'd1));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule